// File: doc/BRIEF.md
# I2C Bus Start/Stop Condition Detector

This block monitors the clock and data lines of a two-wire serial bus, after resynchronising them into the system clock domain, and reports START and STOP conditions. A data-line transition counts as a condition only when the clock line has been high long enough. A 5-bit window value, expressed in system clock cycles, sets that minimum. For a START the clock must also stay high for the same window after the data line falls. Each accepted condition produces a one-cycle pulse, and a busy flag follows the bus from START to STOP.

A second function is an edge interrupt request. It is taken from either the clock or the data line, and either edge direction can be selected. The request is sticky until software clears it. The selected line is compared with its previous value after the selection, polarity and enable settings have been applied. Changing any of those settings can therefore raise the request, and software is expected to clear it after reconfiguring.

Top module: `i2ccd_top`

## Requirements
- R1: Both bus lines pass through a two-flop synchronizer. A data-line change that is accepted as a STOP drives `stop_pulse` high during the third clock cycle after the pin change is sampled, and low again in the fourth.
- R2: A START is a falling edge on the synchronized data line while the clock line is high. Before the edge, the clock must have been high for at least `win_cfg` cycles. After the edge, it must stay high for `win_cfg` more samples with the data line low. The block then emits a single-cycle `start_pulse`.
- R3: A STOP is a rising edge on the synchronized data line while the clock line is high, after the clock has been high for at least `win_cfg` cycles. It emits a single-cycle `stop_pulse`. A rising data edge also cancels any START still waiting out its post-edge window.
- R4: The pre-edge window is exact. Holding the clock high for exactly `win_cfg` sampled cycles before the data edge qualifies the condition, and `win_cfg`-1 cycles does not.
- R5: A `win_cfg` of zero or any odd value is illegal. While it is applied, `cfg_err` is 1 and no START or STOP pulse is produced. For legal even values `cfg_err` is 0.
- R6: `busy` goes to 1 the cycle after a `start_pulse`. It goes to 0 the cycle after a `stop_pulse`, and is held at 0 the cycle after `enable` is 0.
- R7: `start_pulse` and `stop_pulse` are never high in the same cycle, and neither is high for two cycles in a row.
- R8: `irq_sel_sda` = 0 takes the edge interrupt from the clock line and 1 takes it from the data line. Edges on the line that is not selected leave `pin_irq` unchanged.
- R9: `irq_pol_rise` = 0 raises the request on a falling edge of the selected line, and 1 raises it on a rising edge. An edge of the other direction leaves `pin_irq` unchanged.
- R10: `pin_irq` stays at 1 until `irq_clr` is sampled high. If a new edge arrives in the same cycle as `irq_clr`, setting wins.
- R11: While `enable` is 0 the interrupt source reads as a low line. Any change of `enable`, `irq_sel_sda` or `irq_pol_rise` that turns the polarity-adjusted source from 0 to 1 sets `pin_irq`.
- R12: While `enable` is 0, no START or STOP pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Interface enable |
| win_cfg | input | 5 | Clock-high window in system cycles (even, non-zero) |
| irq_sel_sda | input | 1 | Interrupt source: 0 clock line, 1 data line |
| irq_pol_rise | input | 1 | Interrupt edge: 0 falling, 1 rising |
| irq_clr | input | 1 | Clears the sticky interrupt request |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| start_pulse | output | 1 | One-cycle START indication |
| stop_pulse | output | 1 | One-cycle STOP indication |
| busy | output | 1 | Bus busy between START and STOP |
| cfg_err | output | 1 | Illegal window setting |
| pin_irq | output | 1 | Sticky edge interrupt request |

## Verification
The bound checker watches every cycle for the properties that hold regardless of bus timing. These are: pulse exclusivity and single-cycle width, silence under an illegal window or while disabled, busy following its set and clear events, and the request staying sticky. The window arithmetic can only be shown by the bench's scenarios. These cover the exact pre-edge boundary, the post-edge hold a START needs, the three-cycle latency, and a START cancelled by a rising data edge. The same holds for the line and polarity selection and for the spurious requests raised by reconfiguration.

// File: rtl/i2ccd_pkg.sv
package i2ccd_pkg;

    localparam int CFG_W       = 5;
    localparam int SYNC_STAGES = 2;

    typedef logic [CFG_W-1:0] win_t;

    typedef struct packed {
        win_t hcnt;
        logic pend;
        win_t acnt;
        logic sda_p;
        logic start;
        logic stop;
        logic busy;
    } cond_st_t;

    typedef struct packed {
        logic vsrc;
        logic irq;
    } irq_st_t;

endpackage

// File: rtl/i2ccd_sync.sv
module i2ccd_sync #(
    parameter int         W       = 2,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/i2ccd_cond.sv
module i2ccd_cond
    import i2ccd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic active,
    input  win_t win,
    input  logic scl,
    input  logic sda,
    output logic start_pulse,
    output logic stop_pulse,
    output logic busy
);
    localparam win_t HMAX = '1;

    cond_st_t q, n;
    logic fall, rise, pre_ok;
    win_t acnt_inc;

    always_comb begin
        n        = q;
        n.start  = 1'b0;
        n.stop   = 1'b0;
        n.sda_p  = sda;
        fall     = q.sda_p & ~sda;
        rise     = ~q.sda_p & sda;
        pre_ok   = scl && (q.hcnt >= win);
        acnt_inc = q.acnt + 1'b1;

        if (!scl)             n.hcnt = '0;
        else if (q.hcnt != HMAX) n.hcnt = q.hcnt + 1'b1;

        if (!active) begin
            n.pend = 1'b0;
            n.acnt = '0;
        end else if (q.pend) begin
            if (!scl || rise) begin
                n.pend = 1'b0;
                n.acnt = '0;
            end else if (acnt_inc == win) begin
                n.start = 1'b1;
                n.pend  = 1'b0;
                n.acnt  = '0;
            end else begin
                n.acnt = acnt_inc;
            end
        end else if (fall && pre_ok) begin
            n.pend = 1'b1;
            n.acnt = '0;
        end

        if (active && rise && pre_ok) n.stop = 1'b1;

        n.busy = enable & (q.start | (q.busy & ~q.stop));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.sda_p <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign start_pulse = q.start;
    assign stop_pulse  = q.stop;
    assign busy        = q.busy;
endmodule

// File: rtl/i2ccd_pinirq.sv
module i2ccd_pinirq
    import i2ccd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sel_sda,
    input  logic pol_rise,
    input  logic clr,
    input  logic scl,
    input  logic sda,
    output logic irq
);
    irq_st_t q, n;
    logic src, hit;

    always_comb begin
        n      = q;
        src    = enable & (sel_sda ? sda : scl);
        n.vsrc = pol_rise ? src : ~src;
        hit    = n.vsrc & ~q.vsrc;
        n.irq  = hit | (q.irq & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign irq = q.irq;
endmodule

// File: rtl/i2ccd_top.sv
module i2ccd_top
    import i2ccd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CFG_W-1:0] win_cfg,
    input  logic             irq_sel_sda,
    input  logic             irq_pol_rise,
    input  logic             irq_clr,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             start_pulse,
    output logic             stop_pulse,
    output logic             busy,
    output logic             cfg_err,
    output logic             pin_irq
);
    logic [1:0] lines_s;
    logic       scl_s, sda_s, win_ok;

    i2ccd_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_in, sda_in}),
        .dout (lines_s)
    );

    assign scl_s  = lines_s[1];
    assign sda_s  = lines_s[0];
    assign win_ok = (win_cfg != '0) && !win_cfg[0];
    assign cfg_err = !win_ok;

    i2ccd_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .active     (enable & win_ok),
        .win        (win_cfg),
        .scl        (scl_s),
        .sda        (sda_s),
        .start_pulse(start_pulse),
        .stop_pulse (stop_pulse),
        .busy       (busy)
    );

    i2ccd_pinirq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .sel_sda (irq_sel_sda),
        .pol_rise(irq_pol_rise),
        .clr     (irq_clr),
        .scl     (scl_s),
        .sda     (sda_s),
        .irq     (pin_irq)
    );
endmodule

// File: rtl/i2ccd_chk.sv
module i2ccd_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic cfg_err,
    input logic irq_clr,
    input logic start_pulse,
    input logic stop_pulse,
    input logic busy,
    input logic pin_irq
);
    a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_pulse && stop_pulse));

    a_r7_start_width: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    a_r7_stop_width: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse);

    a_r5_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> (!start_pulse && !stop_pulse));

    a_r12_dis_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!start_pulse && !stop_pulse));

    a_r6_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_pulse));

    a_r6_busy_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !busy);

    a_r6_busy_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !busy);

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_irq && !irq_clr) |=> pin_irq);
endmodule

bind i2ccd_top i2ccd_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cfg_err    (cfg_err),
    .irq_clr    (irq_clr),
    .start_pulse(start_pulse),
    .stop_pulse (stop_pulse),
    .busy       (busy),
    .pin_irq    (pin_irq)
);

// File: tb/tb_i2ccd_top.sv
module tb_i2ccd_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [4:0] win_cfg = 5'd4;
    logic       irq_sel_sda = 1'b0;
    logic       irq_pol_rise = 1'b1;
    logic       irq_clr = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       start_pulse, stop_pulse, busy, cfg_err, pin_irq;

    int checks = 0;
    int errors = 0;
    int n_start = 0;
    int n_stop = 0;
    bit exp_busy = 1'b0;

    always #10 clk = ~clk;

    i2ccd_top dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .win_cfg(win_cfg),
        .irq_sel_sda(irq_sel_sda), .irq_pol_rise(irq_pol_rise), .irq_clr(irq_clr),
        .scl_in(scl_in), .sda_in(sda_in), .start_pulse(start_pulse),
        .stop_pulse(stop_pulse), .busy(busy), .cfg_err(cfg_err), .pin_irq(pin_irq)
    );

    always @(negedge clk) begin
        if (start_pulse) n_start++;
        if (stop_pulse)  n_stop++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit legal(input int w);
        return (w != 0) && (w % 2 == 0);
    endfunction

    function automatic int exp_start(input int p, input int q, input int w, input bit en);
        return (en && legal(w) && p >= w && q >= w + 1) ? 1 : 0;
    endfunction

    function automatic int exp_stop(input int p, input int w, input bit en);
        return (en && legal(w) && p >= w) ? 1 : 0;
    endfunction

    task automatic tx_start(input string req, input int p, input int q);
        int s0 = n_start;
        int e = exp_start(p, q, int'(win_cfg), enable);
        scl_in = 1'b0; tick(1);
        sda_in = 1'b1; tick(2);
        scl_in = 1'b1; tick(p);
        sda_in = 1'b0; tick(q);
        scl_in = 1'b0; tick(6);
        chk(req, n_start - s0, e);
        exp_busy = enable ? (e == 1 ? 1'b1 : exp_busy) : 1'b0;
        chk("R6 busy after start", int'(busy), int'(exp_busy));
    endtask

    task automatic tx_stop(input string req, input int p);
        int s0 = n_stop;
        int e = exp_stop(p, int'(win_cfg), enable);
        scl_in = 1'b0; tick(1);
        sda_in = 1'b0; tick(2);
        scl_in = 1'b1; tick(p);
        sda_in = 1'b1; tick(6);
        scl_in = 1'b0; tick(2);
        chk(req, n_stop - s0, e);
        exp_busy = enable ? (e == 1 ? 1'b0 : exp_busy) : 1'b0;
        chk("R6 busy after stop", int'(busy), int'(exp_busy));
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1; tick(1);
        irq_clr = 1'b0; tick(1);
    endtask

    initial begin
        tick(200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int s0, t0;
        void'($urandom(32'd5150));
        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk("R6 reset busy", int'(busy), 0);
        chk("R10 reset irq", int'(pin_irq), 0);
        chk("R7 reset start", int'(start_pulse), 0);
        chk("R7 reset stop", int'(stop_pulse), 0);

        enable = 1'b1;
        win_cfg = 5'd4;
        tick(4);
        chk("R5 legal window", int'(cfg_err), 0);

        // R2 / R3 basic
        tx_start("R2 start accepted", 8, 8);
        tx_stop("R3 stop accepted", 8);
        // R2 post-edge hold too short
        tx_start("R2 short hold after fall", 8, 3);
        // R4 exact boundary
        tx_start("R4 start exact window", 4, 5);
        tx_stop("R4 stop exact window", 4);
        tx_start("R4 start one short", 3, 8);
        tx_stop("R4 stop one short", 3);

        // R1 latency of stop
        scl_in = 1'b0; tick(1); sda_in = 1'b0; tick(2);
        scl_in = 1'b1; tick(10);
        sda_in = 1'b1;
        tick(2); chk("R1 stop not yet", int'(stop_pulse), 0);
        tick(1); chk("R1 stop at third cycle", int'(stop_pulse), 1);
        tick(1); chk("R1 stop one cycle", int'(stop_pulse), 0);
        scl_in = 1'b0; tick(4);
        exp_busy = 1'b0;

        // R3 cancel of a pending start
        s0 = n_start; t0 = n_stop;
        sda_in = 1'b1; tick(2);
        scl_in = 1'b1; tick(6);
        sda_in = 1'b0; tick(1);
        sda_in = 1'b1; tick(8);
        scl_in = 1'b0; tick(4);
        chk("R3 cancelled start", n_start - s0, 0);
        chk("R3 stop on cancel", n_stop - t0, 1);

        // R5 illegal windows
        win_cfg = 5'd0; tick(1);
        chk("R5 zero window err", int'(cfg_err), 1);
        tx_start("R5 zero window no start", 10, 10);
        win_cfg = 5'd7; tick(1);
        chk("R5 odd window err", int'(cfg_err), 1);
        tx_stop("R5 odd window no stop", 12);
        win_cfg = 5'd6; tick(1);
        chk("R5 even window ok", int'(cfg_err), 0);

        // R12 / R6 disable
        tx_start("R6 start sets busy", 9, 9);
        enable = 1'b0; tick(2);
        chk("R6 disable clears busy", int'(busy), 0);
        exp_busy = 1'b0;
        tx_start("R12 disabled no start", 9, 9);
        tx_stop("R12 disabled no stop", 9);
        enable = 1'b1; tick(2);

        // Interrupt tests
        scl_in = 1'b1; sda_in = 1'b1;
        irq_sel_sda = 1'b0; irq_pol_rise = 1'b0;
        tick(5); clear_irq(); tick(3);
        chk("R10 cleared", int'(pin_irq), 0);
        scl_in = 1'b0; tick(5);
        chk("R9 falling scl sets", int'(pin_irq), 1);
        clear_irq();
        chk("R10 clear works", int'(pin_irq), 0);
        scl_in = 1'b1; tick(5);
        chk("R9 rising ignored on fall pol", int'(pin_irq), 0);
        sda_in = 1'b0; tick(4); sda_in = 1'b1; tick(5);
        chk("R8 unselected sda ignored", int'(pin_irq), 0);
        irq_sel_sda = 1'b1; irq_pol_rise = 1'b1; tick(3);
        chk("R11 reconfig spurious set", int'(pin_irq), 1);
        clear_irq();
        sda_in = 1'b0; tick(5);
        chk("R9 falling ignored on rise pol", int'(pin_irq), 0);
        sda_in = 1'b1; tick(5);
        chk("R8 sda rising sets", int'(pin_irq), 1);
        clear_irq();
        sda_in = 1'b0; tick(5);
        irq_clr = 1'b1;
        sda_in = 1'b1;
        tick(3); chk("R10 set beats clear", int'(pin_irq), 1);
        tick(1); chk("R10 clear after set", int'(pin_irq), 0);
        irq_clr = 1'b0;
        irq_sel_sda = 1'b0; scl_in = 1'b1;
        tick(4); clear_irq();
        enable = 1'b0; tick(3); clear_irq();
        chk("R11 disabled source low", int'(pin_irq), 0);
        enable = 1'b1; tick(2);
        chk("R11 enable raises request", int'(pin_irq), 1);
        clear_irq();
        exp_busy = busy;

        // Random transactions
        for (int i = 0; i < 80; i++) begin
            int w = ($urandom % 8 == 0) ? int'($urandom % 13) : 2 * (1 + int'($urandom % 6));
            int p = int'($urandom % (w + 6));
            int q = int'($urandom % (w + 6));
            bit en = ($urandom % 10) != 0;
            win_cfg = 5'(w);
            enable = en;
            tick(2);
            if (!en) exp_busy = 1'b0;
            if ($urandom % 2 == 0) tx_start("R2 random start", p, q);
            else                   tx_stop("R3 random stop", p);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule